// File: doc/BRIEF.md
# Microwire serial EEPROM device controller

This block models the device end of a three-wire serial EEPROM holding 1024 bits. A host raises the select line, clocks an instruction in on the data input one bit per rising serial clock, and lowers select again. The block decodes the instruction and does one of several things. It can stream stored data back on the data output. It can set or clear a write-enable latch. It can also run a self-timed programming cycle that writes or erases one location or the whole array. A static organisation input chooses between 64 words of 16 bits and 128 bytes of 8 bits.

All pins are sampled by a faster system clock through a synchroniser, and edges of the serial clock and select line are found from the sampled values. The programming time is a parameter counted in system clocks. While programming runs, the host can raise select to poll a busy/ready flag on the data output. Outside a read or a status poll, the output enable stays low.

Top module: `mw_eeprom_dev`

## Requirements
- R1: An instruction is a 1 start bit, then a 2-bit opcode, then the address, then data where the operation takes it, all MSB first; zeros clocked before the start bit are ignored.
- R2: Opcode 10 reads, 01 writes and 11 erases one location; under opcode 00 the two top address bits select 11 = write enable, 00 = write disable, 10 = erase all, 01 = write all, and the lower address bits are ignored.
- R3: With the organisation input high the array is 64x16 with a 6-bit address; with it low it is 128x8 with a 7-bit address; 16-bit word n holds byte 2n in bits 15:8 and byte 2n+1 in bits 7:0.
- R4: A non-read instruction acts only if exactly 9 (x16) or 10 (x8) SK cycles were clocked for the short forms, or 25 (x16) or 18 (x8) for write and write-all; any other count has no effect.
- R5: On the rising SK edge that takes the last read address bit, the output is enabled and shows 0; each later rising SK edge presents the next data bit, MSB first.
- R6: While select stays high, a read goes on to the next higher address after each location, wrapping from the top location to 0.
- R7: The write-enable latch is clear after reset, set by write enable and cleared by write disable; write, erase, write-all and erase-all have no effect while it is clear.
- R8: Programming starts when select falls after a complete write-type instruction; write stores the data, erase sets the location to all ones, write-all stores the pattern in every location, erase-all sets every bit to one.
- R9: If select is raised while programming runs, the output is enabled and shows 0 while busy and 1 once ready; if select is raised after programming has ended, the output stays disabled.
- R10: The output enable is low after reset, whenever select is low, and whenever the block is neither reading nor reporting status.
- R11: Instructions clocked in while programming runs are ignored.
- R12: Lowering select in the middle of an instruction discards it, and the next instruction is decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data is taken on its rising edge |
| din | input | 1 | Serial instruction and data input |
| org | input | 1 | Organisation select: 1 = 64x16, 0 = 128x8 |
| dout | output | 1 | Serial read data or busy/ready flag |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The bench sends instructions one SK cycle too long or too short. A design that counts loosely would then program, or would apply a disable it should have dropped. It reads across the top of the array in both organisations, where a design that drops the wrap would return the wrong location or stop. It sends a full write while programming is still running, and it raises select after programming has ended. A design that fails to lock out the shifter would corrupt a second location, and one that keeps the status latched would drive the output when it should not. Random writes and erases under both organisations are checked against a byte-level model of the array, and a wrong byte order inside a 16-bit word shows up there.

// File: rtl/mw_pkg.sv
package mw_pkg;

  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int WORD_CNT  = 64;
  localparam int WADDR_W   = $clog2(WORD_CNT);
  localparam int BADDR_W   = WADDR_W + 1;
  localparam int SHIFT_W   = 2 + WADDR_W + WORD_W;
  localparam int CNT_W     = $clog2(SHIFT_W + 1);

  typedef enum logic [2:0] {
    C_NONE, C_READ, C_WRITE, C_ERASE, C_WEN, C_WDS, C_ERAL, C_WRAL
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_DONE, S_READ, S_BAD
  } sh_st_e;

  function automatic logic [CNT_W-1:0] f_addr_w(input logic org16);
    return org16 ? CNT_W'(WADDR_W) : CNT_W'(BADDR_W);
  endfunction

  function automatic logic [CNT_W-1:0] f_data_w(input logic org16);
    return org16 ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
  endfunction

  function automatic logic [BADDR_W-1:0] f_addr_mask(input logic org16);
    return org16 ? BADDR_W'((1 << WADDR_W) - 1) : BADDR_W'((1 << BADDR_W) - 1);
  endfunction

  function automatic logic [WORD_W-1:0] f_data_mask(input logic org16);
    return org16 ? WORD_W'((1 << WORD_W) - 1) : WORD_W'((1 << BYTE_W) - 1);
  endfunction

  // opcode plus the two top address bits give the operation
  function automatic cmd_e f_decode(input logic [1:0] op, input logic [1:0] sub);
    case (op)
      2'b10:   return C_READ;
      2'b01:   return C_WRITE;
      2'b11:   return C_ERASE;
      default: begin
        case (sub)
          2'b11:   return C_WEN;
          2'b00:   return C_WDS;
          2'b10:   return C_ERAL;
          default: return C_WRAL;
        endcase
      end
    endcase
  endfunction

  function automatic logic f_has_data(input cmd_e c);
    return (c == C_WRITE) || (c == C_WRAL);
  endfunction

  function automatic logic f_is_prog(input cmd_e c);
    return (c == C_WRITE) || (c == C_WRAL) || (c == C_ERASE) || (c == C_ERAL);
  endfunction

  function automatic logic [BADDR_W-1:0] f_next_addr(input logic [BADDR_W-1:0] a,
                                                     input logic org16);
    return (a + 1'b1) & f_addr_mask(org16);
  endfunction

endpackage

// File: rtl/mw_in_sync.sv
module mw_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  localparam int PIPE_W = W * STAGES;

  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[PIPE_W-W-1:0], d_in};
  end

  assign d_out = pipe_q[PIPE_W-1 -: W];

  initial begin
    a_stages_r10: assert (STAGES >= 2) else $error("synchroniser needs two stages");
  end
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (start)       left_q <= TW'(CYCLES);
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
  assign done = (left_q == TW'(1));

  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/mw_eeprom_dev.sv
module mw_eeprom_dev
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic din,
  input  logic org,
  output logic dout,
  output logic dout_oe
);
  // ---------------- pin sampling and edges ----------------
  logic [3:0] pins_s;
  logic cs_s, sk_s, din_s, org_s, cs_q, sk_q;
  logic cs_rise, cs_fall, sk_rise, sk_evt;

  mw_in_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({org, din, sk, cs}),
    .d_out(pins_s)
  );

  assign cs_s  = pins_s[0];
  assign sk_s  = pins_s[1];
  assign din_s = pins_s[2];
  assign org_s = pins_s[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_s;
      sk_q <= sk_s;
    end
  end

  assign cs_rise = cs_s & ~cs_q;
  assign cs_fall = ~cs_s & cs_q;
  assign sk_rise = sk_s & ~sk_q;
  assign sk_evt  = sk_rise & cs_s;

  // ---------------- storage ----------------
  logic [WORD_W-1:0] mem [WORD_CNT];

  // aligned read word: a byte sits in bits 15:8 so the shifter always takes bit 15
  function automatic logic [WORD_W-1:0] word_at(input logic [BADDR_W-1:0] a,
                                                input logic org16);
    logic [WORD_W-1:0] w;
    if (org16) begin
      w = mem[a[WADDR_W-1:0]];
    end else begin
      w = mem[a[BADDR_W-1:1]];
      w = a[0] ? {w[BYTE_W-1:0], {BYTE_W{1'b0}}} : {w[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
    end
    return w;
  endfunction

  // ---------------- instruction shifter ----------------
  sh_st_e               st;
  logic [CNT_W-1:0]     bitcnt;
  logic [SHIFT_W-2:0]   sh;
  logic [SHIFT_W-1:0]   nxt;
  cmd_e                 cmd_q, hdr_cmd;
  logic [BADDR_W-1:0]   addr_q, rd_addr, addr_w, rd_next;
  logic [WORD_W-1:0]    data_q, data_full, out_sr;
  logic [CNT_W-1:0]     out_left, aw, dw, hdr_len, full_len, bc1;
  logic [1:0]           op_w, sub_w;
  logic                 dout_q, wel, stat_mode;
  logic                 busy, prog_done, prog_start, commit, prog_org;

  assign nxt       = {sh, din_s};
  assign aw        = f_addr_w(org_s);
  assign dw        = f_data_w(org_s);
  assign hdr_len   = CNT_W'(2) + aw;
  assign full_len  = hdr_len + dw;
  assign bc1       = bitcnt + 1'b1;
  assign op_w      = 2'(nxt >> aw);
  assign sub_w     = 2'(nxt >> (aw - CNT_W'(2)));
  assign addr_w    = BADDR_W'(nxt) & f_addr_mask(org_s);
  assign data_full = WORD_W'(nxt) & f_data_mask(org_s);
  assign hdr_cmd   = f_decode(op_w, sub_w);
  assign rd_next   = f_next_addr(rd_addr, org_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      cmd_q     <= C_NONE;
      addr_q    <= '0;
      data_q    <= '0;
      rd_addr   <= '0;
      out_sr    <= '0;
      out_left  <= '0;
      dout_q    <= 1'b0;
      stat_mode <= 1'b0;
    end else if (!cs_s) begin
      st        <= S_IDLE;
      stat_mode <= 1'b0;
    end else begin
      if (cs_rise && busy) stat_mode <= 1'b1;
      if (sk_evt) begin
        case (st)
          S_IDLE: begin
            if (!busy && din_s) begin
              st        <= S_SHIFT;
              bitcnt    <= '0;
              sh        <= '0;
              stat_mode <= 1'b0;
            end
          end
          S_SHIFT: begin
            sh     <= nxt[SHIFT_W-2:0];
            bitcnt <= bc1;
            if (bc1 == hdr_len) begin
              cmd_q  <= hdr_cmd;
              addr_q <= addr_w;
              if (hdr_cmd == C_READ) begin
                st       <= S_READ;
                dout_q   <= 1'b0;
                rd_addr  <= addr_w;
                out_sr   <= word_at(addr_w, org_s);
                out_left <= dw;
              end else if (!f_has_data(hdr_cmd)) begin
                st <= S_DONE;
              end
            end else if (bc1 == full_len) begin
              data_q <= data_full;
              st     <= S_DONE;
            end
          end
          S_DONE: st <= S_BAD;
          S_READ: begin
            dout_q <= out_sr[WORD_W-1];
            if (out_left == CNT_W'(1)) begin
              rd_addr  <= rd_next;
              out_sr   <= word_at(rd_next, org_s);
              out_left <= dw;
            end else begin
              out_sr   <= out_sr << 1;
              out_left <= out_left - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- enable latch and programming ----------------
  assign commit     = cs_fall && (st == S_DONE) && !busy;
  assign prog_start = commit && wel && f_is_prog(cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      prog_org <= 1'b1;
    end else begin
      if (commit && cmd_q == C_WEN) wel <= 1'b1;
      if (commit && cmd_q == C_WDS) wel <= 1'b0;
      if (prog_start)               prog_org <= org_s;
    end
  end

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(prog_start),
    .busy (busy),
    .done (prog_done)
  );

  always_ff @(posedge clk) begin
    if (prog_done) begin
      case (cmd_q)
        C_ERAL: for (int i = 0; i < WORD_CNT; i++) mem[i] <= '1;
        C_WRAL: for (int i = 0; i < WORD_CNT; i++)
                  mem[i] <= prog_org ? data_q : {data_q[BYTE_W-1:0], data_q[BYTE_W-1:0]};
        C_WRITE: begin
          if (prog_org)      mem[addr_q[WADDR_W-1:0]] <= data_q;
          else if (addr_q[0]) mem[addr_q[BADDR_W-1:1]][BYTE_W-1:0] <= data_q[BYTE_W-1:0];
          else               mem[addr_q[BADDR_W-1:1]][WORD_W-1:BYTE_W] <= data_q[BYTE_W-1:0];
        end
        C_ERASE: begin
          if (prog_org)      mem[addr_q[WADDR_W-1:0]] <= '1;
          else if (addr_q[0]) mem[addr_q[BADDR_W-1:1]][BYTE_W-1:0] <= '1;
          else               mem[addr_q[BADDR_W-1:1]][WORD_W-1:BYTE_W] <= '1;
        end
        default: ;
      endcase
    end
  end

  // ---------------- output ----------------
  assign dout_oe = cs_s & (stat_mode | (st == S_READ));
  assign dout    = dout_oe & (stat_mode ? ~busy : dout_q);

  // ---------------- assertions ----------------
  p_busy_locks_shifter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == S_IDLE));
  p_cs_drop_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_s) |=> (st == S_IDLE) && !stat_mode);
  p_read_dummy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ) && ($past(st) != S_READ) |-> !dout_q);
  p_prog_needs_wel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  p_exact_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) && ($past(st) == S_SHIFT) |->
      (bitcnt == (f_has_data(cmd_q) ? full_len : hdr_len)));
endmodule

// File: tb/tb_mw_eeprom_dev.sv
module tb_mw_eeprom_dev;
  localparam int PROG = 400;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, din = 1'b0, org = 1'b1;
  logic dout, oe;
  int   n_chk = 0, n_fail = 0;
  bit   fin = 0;
  logic [7:0] model [128];

  mw_eeprom_dev #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .din(din), .org(org),
    .dout(dout), .dout_oe(oe)
  );

  always #10 clk = ~clk;

  function automatic int f_aw(bit o);    return o ? 6 : 7;     endfunction
  function automatic int f_dw(bit o);    return o ? 16 : 8;    endfunction
  function automatic int f_locs(bit o);  return o ? 64 : 128;  endfunction
  function automatic logic [6:0] f_sa(bit o, logic [1:0] s);
    return 7'(s) << (f_aw(o) - 2);
  endfunction
  function automatic logic [15:0] m_get(bit o, int a);
    return o ? {model[2*a], model[2*a+1]} : {8'h00, model[a]};
  endfunction

  task automatic m_put(bit o, int a, logic [15:0] d);
    if (o) begin model[2*a] = d[15:8]; model[2*a+1] = d[7:0]; end
    else model[a] = d[7:0];
  endtask

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse(bit b);
    din = b; sk = 1'b0; tick(4);
    sk = 1'b1; tick(4);
  endtask

  task automatic send(bit o, logic [1:0] op, logic [6:0] a, logic [15:0] d,
                      bit long_f, int extra, int zeros, bit close);
    logic [31:0] v;
    int n;
    int aw = f_aw(o);
    int dw = f_dw(o);
    org = o; tick(4);
    cs = 1'b1; tick(2);
    repeat (zeros) pulse(1'b0);
    v = 1;
    v = (v << 2) | 32'(op);
    v = (v << aw) | (32'(a) & ((32'd1 << aw) - 1));
    n = 3 + aw;
    if (long_f) begin
      v = (v << dw) | (32'(d) & ((32'd1 << dw) - 1));
      n = n + dw;
    end
    if (extra > 0) begin v = v << extra; n = n + extra; end
    else if (extra < 0) begin v = v >> (-extra); n = n + extra; end
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    if (close) begin sk = 1'b0; tick(4); cs = 1'b0; tick(6); end
  endtask

  task automatic wait_prog(string tag);
    cs = 1'b1; tick(6);
    chk(oe === 1'b1 && dout === 1'b0, {tag, " R9 busy flag"}, {oe, dout}, 2'b10);
    tick(PROG + 10);
    chk(oe === 1'b1 && dout === 1'b1, {tag, " R9 ready flag"}, {oe, dout}, 2'b11);
    cs = 1'b0; tick(4);
  endtask

  task automatic expect_quiet(string tag);
    cs = 1'b1; tick(6);
    chk(oe === 1'b0, tag, oe, 0);
    cs = 1'b0; tick(4);
  endtask

  task automatic rd(bit o, int a, int nw, string tag);
    int cur = a;
    send(o, 2'b10, 7'(a), 16'h0, 1'b0, 0, 0, 1'b0);
    chk(oe === 1'b1 && dout === 1'b0, {tag, " R5 dummy zero"}, {oe, dout}, 2'b10);
    for (int w = 0; w < nw; w++) begin
      logic [15:0] val = '0;
      for (int b = 0; b < f_dw(o); b++) begin
        pulse(1'b0);
        val = {val[14:0], dout};
      end
      chk(val === m_get(o, cur), {tag, " R3 R6 read data"}, val, m_get(o, cur));
      cur = (cur + 1) % f_locs(o);
    end
    sk = 1'b0; tick(2); cs = 1'b0; tick(4);
    chk(oe === 1'b0, {tag, " R10 released"}, oe, 0);
  endtask

  task automatic wen(bit o);  send(o, 2'b00, f_sa(o, 2'b11), 16'h0, 1'b0, 0, 0, 1'b1); endtask
  task automatic wds(bit o);  send(o, 2'b00, f_sa(o, 2'b00), 16'h0, 1'b0, 0, 0, 1'b1); endtask

  task automatic do_write(bit o, int a, logic [15:0] d, string tag);
    send(o, 2'b01, 7'(a), d, 1'b1, 0, 0, 1'b1);
    wait_prog(tag);
    m_put(o, a, d);
  endtask

  task automatic do_erase(bit o, int a, string tag);
    send(o, 2'b11, 7'(a), 16'h0, 1'b0, 0, 0, 1'b1);
    wait_prog(tag);
    m_put(o, a, 16'hFFFF);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h00C0FFEE);
    tick(5);
    chk(oe === 1'b0, "R10 reset state", oe, 0);
    rst_n = 1'b1; tick(4);

    // R2 R7 enable, then erase everything
    wen(1'b1);
    expect_quiet("R2 WEN starts no programming");
    send(1'b1, 2'b00, f_sa(1'b1, 2'b10), 16'h0, 1'b0, 0, 0, 1'b1);
    wait_prog("R8 erase all");
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    rd(1'b1, 0, 3, "R8 erase all");

    // R7 write blocked after disable
    wds(1'b1);
    send(1'b1, 2'b01, 7'd5, 16'h1234, 1'b1, 0, 0, 1'b1);
    expect_quiet("R7 write under disable");
    rd(1'b1, 5, 1, "R7 write under disable");

    // R1 R8 writes in both organisations
    wen(1'b1);
    do_write(1'b1, 5, 16'h1234, "R8 write x16");
    rd(1'b1, 5, 1, "R8 write x16");
    send(1'b0, 2'b01, 7'h21, 16'h005A, 1'b1, 0, 3, 1'b1);
    wait_prog("R1 leading zeros");
    m_put(1'b0, 'h21, 16'h005A);
    rd(1'b0, 'h21, 1, "R1 leading zeros");
    rd(1'b1, 'h10, 1, "R3 byte order in word");

    // R4 wrong lengths
    send(1'b1, 2'b01, 7'd7, 16'hAAAA, 1'b1, 1, 0, 1'b1);
    expect_quiet("R4 long write");
    send(1'b0, 2'b01, 7'd9, 16'h0033, 1'b1, -1, 0, 1'b1);
    expect_quiet("R4 short write");
    send(1'b1, 2'b11, 7'd5, 16'h0, 1'b0, 1, 0, 1'b1);
    expect_quiet("R4 long erase");
    send(1'b1, 2'b00, f_sa(1'b1, 2'b00), 16'h0, 1'b0, 1, 0, 1'b1);
    do_write(1'b1, 8, 16'hBEEF, "R4 long disable ignored");
    rd(1'b1, 5, 1, "R4 erase kept out");
    rd(1'b1, 7, 1, "R4 write kept out");
    rd(1'b0, 9, 1, "R4 short write kept out");

    // R6 wrap
    do_write(1'b1, 63, 16'hA5C3, "R6 top word");
    rd(1'b1, 62, 4, "R6 wrap x16");
    do_write(1'b0, 127, 16'h0096, "R6 top byte");
    rd(1'b0, 126, 4, "R6 wrap x8");

    // R8 single erase
    do_erase(1'b1, 5, "R8 erase x16");
    rd(1'b1, 5, 1, "R8 erase x16");
    do_erase(1'b0, 'h21, "R8 erase x8");
    rd(1'b0, 'h20, 2, "R8 erase x8");

    // R12 abort mid-instruction
    org = 1'b1; tick(4); cs = 1'b1; tick(2);
    pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1); pulse(1'b0);
    sk = 1'b0; tick(2); cs = 1'b0; tick(6);
    rd(1'b1, 8, 1, "R12 after abort");

    // R11 ignore while busy, R9 no status after finish
    send(1'b0, 2'b01, 7'd3, 16'h0011, 1'b1, 0, 0, 1'b1);
    cs = 1'b1; tick(6);
    chk(oe === 1'b1 && dout === 1'b0, "R9 busy flag early", {oe, dout}, 2'b10);
    cs = 1'b0; tick(4);
    send(1'b0, 2'b01, 7'd4, 16'h0022, 1'b1, 0, 0, 1'b1);
    m_put(1'b0, 3, 16'h0011);
    tick(PROG + 20);
    expect_quiet("R9 no status after finish");
    rd(1'b0, 3, 2, "R11 second write ignored");

    // R2 R8 write all in both organisations
    send(1'b1, 2'b00, f_sa(1'b1, 2'b01), 16'h0F0F, 1'b1, 0, 0, 1'b1);
    wait_prog("R8 write all x16");
    for (int i = 0; i < 64; i++) m_put(1'b1, i, 16'h0F0F);
    rd(1'b1, 20, 2, "R8 write all x16");
    send(1'b0, 2'b00, f_sa(1'b0, 2'b01) | 7'h0B, 16'h003C, 1'b1, 0, 0, 1'b1);
    wait_prog("R2 write all x8");
    for (int i = 0; i < 128; i++) model[i] = 8'h3C;
    rd(1'b0, 100, 3, "R2 write all x8");

    // random mix
    for (int it = 0; it < 14; it++) begin
      bit o = 1'($urandom);
      int a = int'($urandom % 32'(f_locs(o)));
      logic [15:0] d = 16'($urandom);
      if (!o) d = d & 16'h00FF;
      if (($urandom % 3) == 0) do_erase(o, a, "R8 random erase");
      else                     do_write(o, a, d, "R8 random write");
      rd(o, a, 1 + int'($urandom % 2), "R3 random read");
    end

    // R7 erase all blocked after disable
    wds(1'b1);
    send(1'b1, 2'b00, f_sa(1'b1, 2'b10), 16'h0, 1'b0, 0, 0, 1'b1);
    expect_quiet("R7 erase all under disable");
    rd(1'b1, 20, 2, "R7 erase all under disable");

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule